// File: doc/BRIEF.md
# Accumulator Processor with Interrupt Cycle

A compact 16-bit processor built around one accumulator. Programs and data share a single read-write memory that sits outside the block behind a synchronous port. The read data arrives one clock after the address is presented, and a write takes effect on the edge where the write strobe is high. Each instruction is handled in stages. The word at the program counter is fetched into the instruction register and the program counter advances. The instruction is then decoded, any operand moves through the address and buffer registers, and the operation completes. Last, the processor checks for a pending interrupt before the next fetch begins.

Numbers held in the accumulator use sign-magnitude form. Addition is carried out in full for both signs, and a zero result always has a positive sign.

An interrupt is taken only at the check stage and only while the internal enable is set. Entry saves the return address in word 0, clears the enable and continues at word 1. A return instruction reloads the program counter from word 0 and sets the enable again, so the interrupted program carries on where it stopped.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held and just after it, `halt` is low and `mem_we` is low. After reset, execution starts at address 0x010 and the interrupt enable is set.
- R2: An instruction carries its opcode in bits 15:12 and a direct word address in bits 11:0. Opcode 0001 copies the addressed word into the accumulator.
- R3: Opcode 0010 writes the accumulator to the addressed word.
- R4: Opcode 0101 adds the addressed word to the accumulator in sign-magnitude form (bit 15 is the sign, bits 14:0 the magnitude). If the signs are equal, the magnitudes are summed and the sign is kept. If they differ, the smaller magnitude is taken from the larger and the result takes the sign of the larger.
- R5: A sum whose magnitude is zero always has sign bit 0, whatever the signs of the operands, including two negative zeros.
- R6: Opcode 0000 stops the processor. `halt` rises and stays high until reset, and no memory write happens after that, even with `irq` high.
- R7: Opcodes other than 0000, 0001, 0010, 0101 and 1111 change neither the accumulator nor any memory word.
- R8: Counting clock edges from the start of a fetch, a load or add takes 8 edges and a store takes 6. After a halt fetch starts, `halt` is high after 4 edges. The write strobe is never high for two edges in a row.
- R9: When `irq` is high at the check stage and the enable is set, the processor writes the return address to word 0. This is the address of the next instruction, with bits 15:12 zero. The next fetch is from address 0x001, and the enable is cleared. After the first load following reset, this entry write occurs on the 8th edge. Word 0 is reserved for this use.
- R10: While the enable is clear, `irq` is ignored. Opcode 1111 reloads the program counter from word 0 and sets the enable. The interrupted program then resumes with the instruction after the one at which it was interrupted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq | input | 1 | Level interrupt request |
| mem_rdata | input | 16 | Read data, valid one clock after the address |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Write strobe, one edge per write |
| halt | output | 1 | High once a halt instruction has executed |

## Verification
Every result comes back through memory or `halt`, so its due cycle follows from the per-instruction edge counts in R8. The bench waits for `halt` and only then reads the stored words. For one program it also counts the edges from reset to `halt` (26 for load, add, store, halt) and checks that the count is exact. The interrupt entry write is sampled on the falling edge in the cycle where the strobe is high: the 8th edge after reset for the first entry. The saved word is read on the next falling edge, after the write edge has landed. All sampling uses falling edges, half a period clear of the edges that change the outputs.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int DW = 16,
  parameter logic [DW-5:0] START_PC = 'h010,
  parameter logic [DW-5:0] ISR_PC = 'h001,
  parameter logic [DW-5:0] SLOT = 'h000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-5:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          halt
);
  localparam int AW = DW - 4;
  localparam int MW = DW - 1;

  typedef enum logic [3:0] {
    F_ADDR, F_WAIT, F_LATCH, DECODE, R_WAIT, R_LATCH, EXEC, WRITE, CHECK, ENTER, STOP
  } state_t;

  localparam logic [3:0] OP_HALT = 4'b0000;
  localparam logic [3:0] OP_LOAD = 4'b0001;
  localparam logic [3:0] OP_STORE = 4'b0010;
  localparam logic [3:0] OP_ADD = 4'b0101;
  localparam logic [3:0] OP_RET = 4'b1111;

  state_t state;
  logic [AW-1:0] pc, mar;
  logic [DW-1:0] ir, mbr, ac;
  logic ien;

  wire [3:0] op = ir[DW-1:DW-4];

  logic [MW-1:0] mag;
  logic sgn;
  always_comb begin
    if (ac[MW] == mbr[MW]) begin
      mag = ac[MW-1:0] + mbr[MW-1:0];
      sgn = ac[MW];
    end else if (ac[MW-1:0] >= mbr[MW-1:0]) begin
      mag = ac[MW-1:0] - mbr[MW-1:0];
      sgn = ac[MW];
    end else begin
      mag = mbr[MW-1:0] - ac[MW-1:0];
      sgn = mbr[MW];
    end
    if (mag == '0) sgn = 1'b0;
  end

  assign mem_addr = mar;
  assign mem_wdata = mbr;
  assign mem_we = (state == WRITE) || (state == ENTER);
  assign halt = (state == STOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= F_ADDR;
      pc <= START_PC;
      mar <= '0;
      ir <= '0;
      mbr <= '0;
      ac <= '0;
      ien <= 1'b1;
    end else begin
      case (state)
        F_ADDR: begin
          mar <= pc;
          state <= F_WAIT;
        end
        F_WAIT: state <= F_LATCH;
        F_LATCH: begin
          ir <= mem_rdata;
          pc <= pc + 1'b1;
          state <= DECODE;
        end
        DECODE: begin
          mar <= ir[AW-1:0];
          case (op)
            OP_HALT: state <= STOP;
            OP_LOAD, OP_ADD: state <= R_WAIT;
            OP_STORE: begin
              mbr <= ac;
              state <= WRITE;
            end
            OP_RET: begin
              mar <= SLOT;
              state <= R_WAIT;
            end
            default: state <= CHECK;
          endcase
        end
        R_WAIT: state <= R_LATCH;
        R_LATCH: begin
          mbr <= mem_rdata;
          state <= EXEC;
        end
        EXEC: begin
          case (op)
            OP_LOAD: ac <= mbr;
            OP_ADD: ac <= {sgn, mag};
            OP_RET: begin
              pc <= mbr[AW-1:0];
              ien <= 1'b1;
            end
            default: ;
          endcase
          state <= CHECK;
        end
        WRITE: state <= CHECK;
        CHECK: begin
          if (ien && irq) begin
            mar <= SLOT;
            mbr <= {{(DW-AW){1'b0}}, pc};
            state <= ENTER;
          end else begin
            state <= F_ADDR;
          end
        end
        ENTER: begin
          pc <= ISR_PC;
          ien <= 1'b0;
          state <= F_ADDR;
        end
        default: state <= STOP;
      endcase
    end
  end
endmodule

module acc_cpu_chk #(
  parameter int DW = 16,
  parameter logic [DW-5:0] ISR_PC = 'h001,
  parameter logic [DW-5:0] SLOT = 'h000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          halt,
  input logic          mem_we,
  input logic [DW-5:0] mem_addr,
  input logic [DW-1:0] mem_wdata
);
  assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);

  assert_halt_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !mem_we);

  assert_single_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  assert_slot_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr == SLOT) |-> (mem_wdata[DW-1:DW-4] == 4'b0000));

  assert_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr == SLOT) |=> ##1 (mem_addr == ISR_PC));
endmodule

bind acc_cpu acc_cpu_chk #(.DW(DW), .ISR_PC(ISR_PC), .SLOT(SLOT)) chk (
  .clk(clk), .rst_n(rst_n), .halt(halt), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/acc_cpu_test.sv
module acc_cpu_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq = 1'b0;
  logic [15:0] mem_rdata;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic mem_we, halt;
  logic [15:0] mem [0:511];
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  acc_cpu uut (
    .clk(clk), .rst_n(rst_n), .irq(irq), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .halt(halt)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[8:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[8:0]];
  end

  localparam logic [47:0] VEC [10] = '{
    {16'h0005, 16'h0003, 16'h0008},
    {16'h8005, 16'h8003, 16'h8008},
    {16'h0005, 16'h8003, 16'h0002},
    {16'h0003, 16'h8005, 16'h8002},
    {16'h8005, 16'h0003, 16'h8002},
    {16'h8003, 16'h0005, 16'h0002},
    {16'h0005, 16'h8005, 16'h0000},
    {16'h8005, 16'h0005, 16'h0000},
    {16'h8000, 16'h8000, 16'h0000},
    {16'h1234, 16'h0111, 16'h1345}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 512; i++) mem[i] = 16'h0000;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_to_halt(output int n);
    n = 0;
    @(negedge clk);
    rst_n = 1'b1;
    while (!halt && n < 2000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R8 actual=timeout expected=halt");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int acks;
    clear_mem();
    hold_reset();
    chk("R1 halt low in reset", {15'd0, halt}, 16'h0000);
    chk("R1 no write in reset", {15'd0, mem_we}, 16'h0000);

    // R2 R4 R5: vector table, program at 0x010 = load, add, store, halt
    for (int i = 0; i < 10; i++) begin
      clear_mem();
      mem[16'h010] = 16'h1100;
      mem[16'h011] = 16'h5101;
      mem[16'h012] = 16'h2102;
      mem[16'h013] = 16'h0000;
      mem[16'h100] = VEC[i][47:32];
      mem[16'h101] = VEC[i][31:16];
      mem[16'h102] = 16'hDEAD;
      hold_reset();
      run_to_halt(n);
      chk("R4 R5 sign-magnitude sum", mem[16'h102], VEC[i][15:0]);
      if (i == 0) chk("R8 edges to halt", 16'(n), 16'd26);
    end

    // R3 R7: unused opcodes leave accumulator and memory alone
    clear_mem();
    mem[16'h010] = 16'h1100;
    mem[16'h011] = 16'h3123;
    mem[16'h012] = 16'h7100;
    mem[16'h013] = 16'h2102;
    mem[16'h014] = 16'h0000;
    mem[16'h100] = 16'h0042;
    mem[16'h123] = 16'h5555;
    hold_reset();
    run_to_halt(n);
    chk("R3 R7 stored accumulator after no-ops", mem[16'h102], 16'h0042);
    chk("R7 no-op target word untouched", mem[16'h123], 16'h5555);
    chk("R7 load source untouched", mem[16'h100], 16'h0042);

    // R6: halted processor ignores irq and writes nothing
    irq = 1'b1;
    acks = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (mem_we) acks++;
    end
    chk("R6 no writes after halt", 16'(acks), 16'd0);
    chk("R6 halt stays high", {15'd0, halt}, 16'h0001);
    irq = 1'b0;

    // R9 R10 R11: interrupt entry, masked re-request, return
    clear_mem();
    mem[16'h001] = 16'h1105;
    mem[16'h002] = 16'h2106;
    mem[16'h003] = 16'hF000;
    mem[16'h010] = 16'h1100;
    mem[16'h011] = 16'h5101;
    mem[16'h012] = 16'h2102;
    mem[16'h013] = 16'h1103;
    mem[16'h014] = 16'h2104;
    mem[16'h015] = 16'h0000;
    mem[16'h100] = 16'h0005;
    mem[16'h101] = 16'h0003;
    mem[16'h103] = 16'h8009;
    mem[16'h105] = 16'h0007;
    hold_reset();
    @(negedge clk);
    rst_n = 1'b1;
    irq = 1'b1;
    n = 0;
    acks = 0;
    while (!halt && n < 2000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (mem_we && mem_addr == 12'h000) begin
        acks++;
        if (acks == 1) begin
          chk("R9 R11 entry on 8th edge", 16'(n), 16'd8);
          @(negedge clk);
          n++;
          chk("R9 saved return address", mem[0], 16'h0011);
          chk("R10 handler not yet run", mem[16'h106], 16'h0000);
        end else begin
          chk("R10 masked until return, handler done", mem[16'h106], 16'h0007);
          irq = 1'b0;
          @(negedge clk);
          n++;
          chk("R10 second saved address", mem[0], 16'h0011);
        end
      end
    end
    chk("R10 entry count", 16'(acks), 16'd2);
    chk("R10 resumed add uses handler accumulator", mem[16'h102], 16'h000A);
    chk("R10 resumed program finishes", mem[16'h104], 16'h8009);
    chk("R6 halt after interrupts", {15'd0, halt}, 16'h0001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule